// File: doc/BRIEF.md
# Stop-Mode Wake-Up Recovery Controller

This block keeps a processor in a low-power stop state and decides when it may leave that state. Software writes a configuration register that picks one wake source from a small set of port pins or pin groups. It also sets whether that source wakes on a high or a low level and whether a long reset-length delay runs before the core restarts. A stop request puts the block into the stop state. In that state the selected source is watched. When the source becomes active, the block either runs a fixed recovery delay or requires the source to stay active for a short qualification window (fast wake). After that it clears the stop flag and sends a single-cycle restart pulse to the core.

A status bit in the same register tells software after restart whether the block came back from stop (warm) or from a reset (cold). Port 3 pins 1 to 3 can be switched to analog use. A pin in analog use never causes a wake. An external reset input always ends the stop state and returns the register to its defaults.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After `rst`, `stop_o` and `restart_o` are 0 and `rd_data_o` reads 0x20: bit 7 (warm flag) 0, bit 6 (wake level) 0, bit 5 (recovery delay enable) 1, bits 4:2 (source code) 000, bits 1:0 always 0.
- R2: A `stop_req_i` pulse while running sets `stop_o` on the next clock edge and sets bit 7 of the register to 1. Bit 7 still reads 1 after a wake caused by the selected source.
- R3: Source code in bits 4:2 selects the wake signal: 001 `p3_i[0]`, 010 `p3_i[1]`, 011 `p3_i[2]`, 100 `p3_i[3]`, 101 `p2_i[7]`, 110 the NOR of `p2_i[3:0]`, 111 the NOR of `p2_i[7:0]`.
- R4: Bit 6 = 1 makes a high level of the selected signal the active level; bit 6 = 0 makes a low level the active one.
- R5: With bit 5 = 1, the restart pulse comes DLY_CYC+2 clock edges after the edge at which the selected source is first seen active. The source may drop meanwhile.
- R6: With bit 5 = 0, the source must be sampled active on FAST_CYC consecutive edges. The restart pulse then comes FAST_CYC+1 edges after the first sampling edge. A shorter activity leaves the block stopped.
- R7: `p3_ana_i[k]` = 1 marks `p3_i[k+1]` as analog. A pin marked analog never wakes the block. Once the mark is cleared while the pin is active, the normal timing from R5/R6 applies from that point.
- R8: Source code 000 ignores all port activity. `ext_rst_i` ends the stop state with a restart pulse on the next edge, and returns the register to 0x20 (cold).
- R9: `restart_o` is high for exactly one cycle, and `stop_o` falls on the same edge.
- R10: Register writes are ignored while `stop_o` is 1. Bit 7 cannot be written at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ext_rst_i | input | 1 | Synchronous external/watchdog reset request |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read value |
| stop_req_i | input | 1 | Request to enter the stop state |
| p2_i | input | 8 | Port 2 pin levels |
| p3_i | input | 4 | Port 3 pin levels, bits 0 to 3 |
| p3_ana_i | input | 3 | Analog-use marks for port 3 pins 1 to 3 |
| stop_o | output | 1 | Stop state active |
| restart_o | output | 1 | One-cycle restart pulse to the core |

## Verification
The inputs change at a falling edge that follows rising edge c. A register write or a stop request shows up at the ports one edge later. An external reset gives its restart pulse at edge c+1. A fast wake gives its restart at edge c+FAST_CYC+1, and a delayed wake at edge c+DLY_CYC+2, because one sampling register sits in front of the sequencer. Each stimulus pushes the edge number at which its restart is due into a queue. A monitor samples at every falling edge, pops on each restart pulse and compares the edge number. Any pulse that arrives when no restart is expected counts as a failure. The "no wake" cases are also checked on `stop_o` after windows longer than the qualification time.

// File: rtl/swk_pkg.sv
package swk_pkg;
  localparam int CFG_W    = 8;
  localparam int P2_W     = 8;
  localparam int P2_LO_W  = 4;
  localparam int P3_W     = 4;
  localparam int SRC_W    = 3;
  localparam int WARM_BIT = 7;
  localparam int LVL_BIT  = 6;
  localparam int DLY_BIT  = 5;
  localparam int SRC_LSB  = 2;
  localparam logic [CFG_W-1:0] CFG_DEFAULT = 8'h20;

  typedef enum logic [SRC_W-1:0] {
    SRC_NONE   = 3'd0,
    SRC_P3B0   = 3'd1,
    SRC_P3B1   = 3'd2,
    SRC_P3B2   = 3'd3,
    SRC_P3B3   = 3'd4,
    SRC_P2B7   = 3'd5,
    SRC_NOR_LO = 3'd6,
    SRC_NOR_ALL= 3'd7
  } wake_src_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_STOP  = 2'd1,
    ST_DELAY = 2'd2
  } swk_state_e;
endpackage

// File: rtl/swk_cfg_reg.sv
module swk_cfg_reg
  import swk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_rst_i,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wr_data_i,
  input  logic             stopped_i,
  input  logic             enter_i,
  output logic [CFG_W-1:0] cfg_o
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (rst || ext_rst_i) begin
      cfg_q <= CFG_DEFAULT;
    end else begin
      if (wr_en_i && !stopped_i)
        cfg_q[WARM_BIT-1:SRC_LSB] <= wr_data_i[WARM_BIT-1:SRC_LSB];
      if (enter_i)
        cfg_q[WARM_BIT] <= 1'b1;
      cfg_q[SRC_LSB-1:0] <= '0;
    end
  end

  assign cfg_o = cfg_q;

  // R10
  wr_stop_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (stopped_i && wr_en_i && !ext_rst_i) |=> $stable(cfg_q[WARM_BIT-1:0]));

  // R2
  warm_on_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (enter_i && !ext_rst_i) |=> cfg_q[WARM_BIT]);

  // R10
  warm_ro_chk: assert property (@(posedge clk) disable iff (rst)
    (!enter_i && !ext_rst_i) |=> $stable(cfg_q[WARM_BIT]));
endmodule

// File: rtl/swk_src_mux.sv
module swk_src_mux
  import swk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [P2_W-1:0]  p2_i,
  input  logic [P3_W-1:0]  p3_i,
  input  logic [P3_W-2:0]  p3_ana_i,
  input  logic [SRC_W-1:0] src_i,
  input  logic             lvl_i,
  output logic             act_o
);
  logic [P3_W-1:0] p3_hit;
  logic            nor_lo, nor_all, sel_act, act_q;

  assign p3_hit[0] = (p3_i[0] == lvl_i);
  for (genvar i = 1; i < P3_W; i++) begin : g_p3_gate
    assign p3_hit[i] = (p3_i[i] == lvl_i) && !p3_ana_i[i-1];
  end

  assign nor_lo  = ~|p2_i[P2_LO_W-1:0];
  assign nor_all = ~|p2_i;

  always_comb begin
    unique case (wake_src_e'(src_i))
      SRC_NONE:    sel_act = 1'b0;
      SRC_P3B0:    sel_act = p3_hit[0];
      SRC_P3B1:    sel_act = p3_hit[1];
      SRC_P3B2:    sel_act = p3_hit[2];
      SRC_P3B3:    sel_act = p3_hit[3];
      SRC_P2B7:    sel_act = (p2_i[P2_W-1] == lvl_i);
      SRC_NOR_LO:  sel_act = (nor_lo == lvl_i);
      SRC_NOR_ALL: sel_act = (nor_all == lvl_i);
      default:     sel_act = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) act_q <= 1'b0;
    else     act_q <= sel_act;
  end

  assign act_o = act_q;

  // R8
  none_src_chk: assert property (@(posedge clk) disable iff (rst)
    (src_i == SRC_NONE) |=> !act_q);

  // R7
  ana_block_chk: assert property (@(posedge clk) disable iff (rst)
    (src_i == SRC_P3B1 && p3_ana_i[0]) |=> !act_q);
endmodule

// File: rtl/swk_seq.sv
module swk_seq
  import swk_pkg::*;
#(
  parameter int FAST_CYC = 5,
  parameter int DLY_CYC  = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_rst_i,
  input  logic stop_req_i,
  input  logic act_i,
  input  logic delay_en_i,
  output logic enter_o,
  output logic stopped_o,
  output logic restart_o
);
  localparam int QW = (FAST_CYC > 1) ? $clog2(FAST_CYC) : 1;
  localparam int DW = (DLY_CYC > 1) ? $clog2(DLY_CYC) : 1;
  localparam logic [QW-1:0] Q_LAST = QW'(FAST_CYC - 1);
  localparam logic [DW-1:0] D_LAST = DW'(DLY_CYC - 1);

  swk_state_e    state_q;
  logic [QW-1:0] qcnt_q;
  logic [DW-1:0] dcnt_q;
  logic          restart_q;

  assign enter_o   = (state_q == ST_RUN) && stop_req_i && !ext_rst_i;
  assign stopped_o = (state_q != ST_RUN);
  assign restart_o = restart_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_RUN;
      qcnt_q    <= '0;
      dcnt_q    <= '0;
      restart_q <= 1'b0;
    end else begin
      restart_q <= 1'b0;
      if (ext_rst_i) begin
        if (state_q != ST_RUN) restart_q <= 1'b1;
        state_q <= ST_RUN;
      end else begin
        unique case (state_q)
          ST_RUN: begin
            if (stop_req_i) begin
              state_q <= ST_STOP;
              qcnt_q  <= '0;
            end
          end
          ST_STOP: begin
            if (!act_i) begin
              qcnt_q <= '0;
            end else if (delay_en_i) begin
              state_q <= ST_DELAY;
              dcnt_q  <= '0;
            end else if (qcnt_q == Q_LAST) begin
              state_q   <= ST_RUN;
              restart_q <= 1'b1;
            end else begin
              qcnt_q <= qcnt_q + 1'b1;
            end
          end
          ST_DELAY: begin
            if (dcnt_q == D_LAST) begin
              state_q   <= ST_RUN;
              restart_q <= 1'b1;
            end else begin
              dcnt_q <= dcnt_q + 1'b1;
            end
          end
          default: state_q <= ST_RUN;
        endcase
      end
    end
  end

  // R9
  pulse_one_chk: assert property (@(posedge clk) disable iff (rst)
    restart_o |=> !restart_o);

  // R9
  fall_with_restart_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(stopped_o) |-> restart_o);

  // R6
  fast_needs_act_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STOP && !delay_en_i && !act_i && !ext_rst_i) |=> !restart_o);

  // R5
  delay_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DELAY && dcnt_q != D_LAST && !ext_rst_i) |=> stopped_o);
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
  import swk_pkg::*;
#(
  parameter int FAST_CYC = 5,
  parameter int DLY_CYC  = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_rst_i,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wr_data_i,
  output logic [CFG_W-1:0] rd_data_o,
  input  logic             stop_req_i,
  input  logic [P2_W-1:0]  p2_i,
  input  logic [P3_W-1:0]  p3_i,
  input  logic [P3_W-2:0]  p3_ana_i,
  output logic             stop_o,
  output logic             restart_o
);
  logic [CFG_W-1:0] cfg;
  logic             enter, stopped, act;

  swk_cfg_reg u_cfg (
    .clk       (clk),
    .rst       (rst),
    .ext_rst_i (ext_rst_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .stopped_i (stopped),
    .enter_i   (enter),
    .cfg_o     (cfg)
  );

  swk_src_mux u_mux (
    .clk      (clk),
    .rst      (rst),
    .p2_i     (p2_i),
    .p3_i     (p3_i),
    .p3_ana_i (p3_ana_i),
    .src_i    (cfg[SRC_LSB+SRC_W-1:SRC_LSB]),
    .lvl_i    (cfg[LVL_BIT]),
    .act_o    (act)
  );

  swk_seq #(.FAST_CYC(FAST_CYC), .DLY_CYC(DLY_CYC)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .ext_rst_i  (ext_rst_i),
    .stop_req_i (stop_req_i),
    .act_i      (act),
    .delay_en_i (cfg[DLY_BIT]),
    .enter_o    (enter),
    .stopped_o  (stopped),
    .restart_o  (restart_o)
  );

  assign rd_data_o = cfg;
  assign stop_o    = stopped;
endmodule

// File: tb/tb_stop_wake_ctrl.sv
module tb_stop_wake_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int FAST_CYC   = 5;
  localparam int DLY_CYC    = 64;

  typedef struct { int cyc; string req; } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_rst = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       stop_req = 1'b0;
  logic [7:0] p2 = 8'hFF;
  logic [3:0] p3 = 4'h0;
  logic [2:0] p3_ana = 3'b000;
  logic       stop_o, restart_o;

  int   total = 0;
  int   bad = 0;
  int   cyc = 0;
  bit   done = 1'b0;
  bit   prev_rs = 1'b0;
  exp_t sb[$];

  stop_wake_ctrl #(.FAST_CYC(FAST_CYC), .DLY_CYC(DLY_CYC)) dut (
    .clk(clk), .rst(rst), .ext_rst_i(ext_rst), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .stop_req_i(stop_req),
    .p2_i(p2), .p3_i(p3), .p3_ana_i(p3_ana), .stop_o(stop_o),
    .restart_o(restart_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_restart(int delta, string req);
    exp_t e;
    e.cyc = cyc + delta;
    e.req = req;
    sb.push_back(e);
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic enter_stop();
    stop_req = 1'b1;
    tick(1);
    stop_req = 1'b0;
    chk("R2 stop_o", int'(stop_o), 1);
  endtask

  // monitor: pops the scoreboard on every restart pulse
  always @(negedge clk) begin
    if (!rst) begin
      if (restart_o) begin
        total++;
        if (sb.size() == 0) begin
          bad++;
          $display("FAIL R9 unexpected restart act=cyc%0d exp=none", cyc);
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (e.cyc != cyc) begin
            bad++;
            $display("FAIL %s restart act=cyc%0d exp=cyc%0d", e.req, cyc, e.cyc);
          end
        end
        chk("R9 stop_o low with restart", int'(stop_o), 0);
        if (prev_rs) begin
          bad++;
          $display("FAIL R9 pulse width act=2 exp=1");
        end
      end
      prev_rs = restart_o;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    chk("R1 rd_data", int'(rd_data), 8'h20);
    chk("R1 stop_o", int'(stop_o), 0);
    chk("R1 restart_o", int'(restart_o), 0);

    // fast wake, p3[0] high; bit7 write attempt (R10)
    wr(8'hC4);
    chk("R10 bit7 read-only", int'(rd_data), 8'h44);
    enter_stop();
    chk("R2 warm set on entry", int'(rd_data), 8'hC4);
    p3[0] = 1'b1;
    tick(FAST_CYC - 1);
    p3[0] = 1'b0;
    tick(8);
    chk("R6 short pulse no wake", int'(stop_o), 1);
    p3[0] = 1'b1;
    expect_restart(FAST_CYC + 1, "R6 fast p3b0");
    tick(10);
    p3[0] = 1'b0;
    chk("R2 warm after wake", int'(rd_data), 8'hC4);

    // delayed wake on p2[7] low level
    p2 = 8'hFF;
    wr(8'h34);
    chk("R10 bit7 kept by write", int'(rd_data), 8'hB4);
    enter_stop();
    wr(8'h00);
    chk("R10 write in stop ignored", int'(rd_data), 8'hB4);
    p2[7] = 1'b0;
    expect_restart(DLY_CYC + 2, "R5 delay p2b7 low R4");
    tick(DLY_CYC - 10);
    chk("R5 still stopped in delay", int'(stop_o), 1);
    tick(20);
    p2 = 8'hFF;

    // analog gating on p3[1]
    wr(8'h48);
    p3_ana = 3'b001;
    enter_stop();
    p3[1] = 1'b1;
    tick(20);
    chk("R7 analog pin no wake", int'(stop_o), 1);
    p3_ana = 3'b000;
    expect_restart(FAST_CYC + 1, "R7 analog released");
    tick(10);
    p3 = 4'h0;

    // p3[2], p3[3]
    wr(8'h4C);
    enter_stop();
    p3[2] = 1'b1;
    expect_restart(FAST_CYC + 1, "R3 src p3b2");
    tick(10);
    p3 = 4'h0;
    wr(8'h50);
    enter_stop();
    p3[3] = 1'b1;
    expect_restart(FAST_CYC + 1, "R3 src p3b3");
    tick(10);
    p3 = 4'h0;

    // low level on p3[0]
    p3 = 4'hF;
    wr(8'h04);
    enter_stop();
    p3[0] = 1'b0;
    expect_restart(FAST_CYC + 1, "R4 low level p3b0");
    tick(10);
    p3 = 4'h0;

    // NOR of p2[3:0]
    p2 = 8'hFF;
    wr(8'h58);
    enter_stop();
    p2 = 8'hF0;
    expect_restart(FAST_CYC + 1, "R3 nor low nibble");
    tick(10);

    // NOR of p2[7:0]
    wr(8'h5C);
    enter_stop();
    tick(10);
    chk("R3 nor all needs all low", int'(stop_o), 1);
    p2 = 8'h00;
    expect_restart(FAST_CYC + 1, "R3 nor all");
    tick(10);
    p2 = 8'hFF;

    // code 000: ports ignored, external reset ends stop
    wr(8'h40);
    enter_stop();
    for (int k = 0; k < 6; k++) begin
      p2 = (k % 2 == 0) ? 8'h00 : 8'hFF;
      p3 = (k % 2 == 0) ? 4'hF : 4'h0;
      tick(8);
    end
    chk("R8 no wake on ports", int'(stop_o), 1);
    chk("R8 cfg kept", int'(rd_data), 8'hC0);
    ext_rst = 1'b1;
    expect_restart(1, "R8 ext reset");
    tick(1);
    ext_rst = 1'b0;
    tick(3);
    chk("R8 cold defaults", int'(rd_data), 8'h20);
    chk("R8 running", int'(stop_o), 0);

    tick(5);
    chk("R9 all restarts seen", sb.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule